// File: doc/BRIEF.md
# Exception and Interrupt Control Coprocessor

This block holds the system-control registers of a 32-bit RISC core: a status word, a cause word, the saved exception PC and a fixed processor identifier. The pipeline presents, each cycle, an optional system-call request together with the PC of the instruction involved and a flag that marks a branch delay slot. The block also samples six interrupt request lines. When an exception is accepted in a cycle, the block raises a redirect strobe with the exception vector in that same cycle. At the next clock edge it saves the return PC, records the cause, and pushes the three-level mode/enable stack held in the six low status bits.

Software reaches the registers through a register-number port. A write strobe with data moves a value in. A combinational read path moves a value out. A return-from-exception strobe pops the mode/enable stack. While reset is held, the redirect strobe is high and the redirect address is the reset vector.

Top module: `sysctl_cop`

## Requirements
- R1: While `rst` is high, `redirect_o` is 1 and `redirect_pc_o` is 0xBFC00000. After reset, register numbers 12, 13 and 14 read 0, and number 15 reads 0x00000002.
- R2: An accepted exception copies status bits [3:0] into bits [5:2] and clears bits [1:0]. Bits [31:6] keep their value.
- R3: A return-from-exception strobe (`rfe_i`) copies status bits [5:2] into bits [3:0]. Bits [31:4] keep their value.
- R4: An accepted exception writes the cause register with the exception code in bits [5:2] and the interrupt field in bits [15:10]; every other bit is zero. A system call uses code 8 with an interrupt field of 0. An interrupt uses code 0, and its interrupt field holds the masked request lines.
- R5: An accepted exception writes the EPC register. The value is `cur_pc_i` minus 4 when `in_dslot_i` is 1, and `cur_pc_i` otherwise.
- R6: In the cycle an exception is accepted, `redirect_o` is 1 and `redirect_pc_o` is 0x80000080. Otherwise, outside reset, `redirect_o` is 0.
- R7: An interrupt is accepted exactly when status bit 0 is 1 and the AND of `irq_i[5:0]` with status bits [13:8] is non-zero.
- R8: A system call with `in_dslot_i` = 1 is ignored. It gives no redirect and leaves status, cause and EPC unchanged.
- R9: When an interrupt and an accepted system call arrive in the same cycle, the interrupt is taken (code 0).
- R10: Register numbers 12, 13, 14 and 15 select status, cause, EPC and processor ID. A read of any other number returns 0. A write to any other number has no effect.
- R11: Writes to register number 15 are ignored; it always reads 0x00000002.
- R12: An accepted exception overrides a register write or a return-from-exception in the same cycle. On the status register, a return-from-exception overrides a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_syscall_i | input | 1 | System-call request from the pipeline |
| cur_pc_i | input | 32 | PC of the instruction presented this cycle |
| in_dslot_i | input | 1 | Instruction sits in a branch delay slot |
| irq_i | input | 6 | Pending interrupt request lines |
| rfe_i | input | 1 | Return-from-exception (pop the mode/enable stack) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_num_i | input | 5 | Register number for the read and the write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_num_i` (combinational) |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 32 | Fetch redirect address |

## Verification
The embedded assertions check several rules on every cycle. They cover the shape of the stack push and pop, the cause layout and the code for each exception kind, and the EPC rewind. They also check that the vector appears whenever the redirect strobe is high, that a disabled global enable never yields an interrupt, and that a delay-slot system call is ignored. Other behaviour is shown only by the bench's scenarios, which run against a behavioural model. These scenarios cover the full mask-versus-line matching, the priority of an exception over a same-cycle write or return, the ignored writes to the identifier and to unmapped numbers, and the reset redirect.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IRQ_N  = 6;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned MASK_LSB = 8;

  localparam logic [4:0] REGNO_STATUS = 5'd12;
  localparam logic [4:0] REGNO_CAUSE  = 5'd13;
  localparam logic [4:0] REGNO_EPC    = 5'd14;
  localparam logic [4:0] REGNO_PRID   = 5'd15;

  localparam logic [CODE_W-1:0] CODE_IRQ     = 4'd0;
  localparam logic [CODE_W-1:0] CODE_SYSCALL = 4'd8;

  typedef enum logic [1:0] {ST_HOLD, ST_PUSH, ST_POP, ST_LOAD} stat_op_e;

  // exception entry: shift the mode/enable stack up by one level
  function automatic logic [WORD_W-1:0] stack_push(logic [WORD_W-1:0] s);
    return (s & 32'hFFFF_FFC0) | {26'b0, s[3:0], 2'b00};
  endfunction

  // exception return: bring the two older levels down, keep the oldest
  function automatic logic [WORD_W-1:0] stack_pop(logic [WORD_W-1:0] s);
    return (s & 32'hFFFF_FFF0) | {28'b0, s[5:2]};
  endfunction

  function automatic logic [WORD_W-1:0] cause_word(logic [CODE_W-1:0] code,
                                                   logic [IRQ_N-1:0] ip);
    return {16'b0, ip, 4'b0, code, 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] epc_value(logic [WORD_W-1:0] pc, logic dslot);
    return dslot ? pc - 32'd4 : pc;
  endfunction
endpackage

// File: rtl/sysctl_irq_detect.sv
module sysctl_irq_detect
  import sysctl_pkg::*;
(
  input  logic [IRQ_N-1:0] irq_lines,
  input  logic [IRQ_N-1:0] irq_mask,
  input  logic             glob_en,
  output logic [IRQ_N-1:0] irq_masked,
  output logic             irq_take
);
  for (genvar i = 0; i < IRQ_N; i++) begin : g_line
    assign irq_masked[i] = irq_lines[i] & irq_mask[i];
  end
  assign irq_take = glob_en & (|irq_masked);
endmodule

// File: rtl/sysctl_status_reg.sv
module sysctl_status_reg
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  stat_op_e          op,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] status_q
);
  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else begin
      case (op)
        ST_PUSH: status_q <= stack_push(status_q);
        ST_POP:  status_q <= stack_pop(status_q);
        ST_LOAD: status_q <= wdata;
        default: status_q <= status_q;
      endcase
    end
  end

  a_r2_push_shift: assert property (@(posedge clk) disable iff (rst)
    op == ST_PUSH |=> status_q[5:2] == $past(status_q[3:0]) && status_q[1:0] == 2'b00
                      && status_q[31:6] == $past(status_q[31:6]));

  a_r3_pop_shift: assert property (@(posedge clk) disable iff (rst)
    op == ST_POP |=> status_q[3:0] == $past(status_q[5:2])
                     && status_q[31:4] == $past(status_q[31:4]));

  a_r12_hold_stable: assert property (@(posedge clk) disable iff (rst)
    op == ST_HOLD |=> $stable(status_q));
endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
  import sysctl_pkg::*;
#(
  parameter logic [31:0] EXC_VECTOR   = 32'h8000_0080,
  parameter logic [31:0] RESET_VECTOR = 32'hBFC0_0000,
  parameter logic [31:0] PRID_VALUE   = 32'h0000_0002
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        exc_syscall_i,
  input  logic [31:0] cur_pc_i,
  input  logic        in_dslot_i,
  input  logic [5:0]  irq_i,
  input  logic        rfe_i,
  input  logic        reg_wr_i,
  input  logic [4:0]  reg_num_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        redirect_o,
  output logic [31:0] redirect_pc_o
);
  logic [WORD_W-1:0] status_q, cause_q, epc_q;
  logic [IRQ_N-1:0]  irq_masked;
  logic              irq_take, sys_take, exc_take;
  logic [CODE_W-1:0] exc_code;
  logic [IRQ_N-1:0]  exc_ip;
  logic              wr_status, wr_cause, wr_epc;
  stat_op_e          stat_op;

  sysctl_irq_detect u_irq (
    .irq_lines (irq_i),
    .irq_mask  (status_q[MASK_LSB +: IRQ_N]),
    .glob_en   (status_q[0]),
    .irq_masked(irq_masked),
    .irq_take  (irq_take)
  );

  // a system call in a delay slot is dropped; interrupts win over calls
  assign sys_take = exc_syscall_i & ~in_dslot_i;
  assign exc_take = irq_take | sys_take;
  assign exc_code = irq_take ? CODE_IRQ : CODE_SYSCALL;
  assign exc_ip   = irq_take ? irq_masked : '0;

  assign wr_status = reg_wr_i && (reg_num_i == REGNO_STATUS);
  assign wr_cause  = reg_wr_i && (reg_num_i == REGNO_CAUSE);
  assign wr_epc    = reg_wr_i && (reg_num_i == REGNO_EPC);

  always_comb begin
    if (exc_take)       stat_op = ST_PUSH;
    else if (rfe_i)     stat_op = ST_POP;
    else if (wr_status) stat_op = ST_LOAD;
    else                stat_op = ST_HOLD;
  end

  sysctl_status_reg u_status (
    .clk     (clk),
    .rst     (rst),
    .op      (stat_op),
    .wdata   (reg_wdata_i),
    .status_q(status_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      epc_q   <= '0;
    end else if (exc_take) begin
      cause_q <= cause_word(exc_code, exc_ip);
      epc_q   <= epc_value(cur_pc_i, in_dslot_i);
    end else begin
      if (wr_cause) cause_q <= reg_wdata_i;
      if (wr_epc)   epc_q   <= reg_wdata_i;
    end
  end

  always_comb begin
    case (reg_num_i)
      REGNO_STATUS: reg_rdata_o = status_q;
      REGNO_CAUSE:  reg_rdata_o = cause_q;
      REGNO_EPC:    reg_rdata_o = epc_q;
      REGNO_PRID:   reg_rdata_o = PRID_VALUE;
      default:      reg_rdata_o = '0;
    endcase
  end

  assign redirect_o    = rst | exc_take;
  assign redirect_pc_o = rst ? RESET_VECTOR : EXC_VECTOR;

  a_r4_cause_zero_bits: assert property (@(posedge clk) disable iff (rst)
    exc_take |=> cause_q[31:16] == 16'b0 && cause_q[9:6] == 4'b0 && cause_q[1:0] == 2'b0);

  a_r9_irq_code: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> cause_q[5:2] == 4'd0 && cause_q[15:10] != 6'd0);

  a_r4_syscall_code: assert property (@(posedge clk) disable iff (rst)
    sys_take && !irq_take |=> cause_q[5:2] == 4'd8 && cause_q[15:10] == 6'd0);

  a_r5_epc_rewind: assert property (@(posedge clk) disable iff (rst)
    exc_take |=> epc_q == ($past(in_dslot_i) ? $past(cur_pc_i) - 32'd4 : $past(cur_pc_i)));

  a_r6_vector: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> redirect_pc_o == EXC_VECTOR);

  a_r7_glob_off: assert property (@(posedge clk) disable iff (rst)
    !status_q[0] |-> !irq_take);

  a_r8_dslot_call: assert property (@(posedge clk) disable iff (rst)
    exc_syscall_i && in_dslot_i && !irq_take && !reg_wr_i && !rfe_i
      |=> $stable(cause_q) && $stable(epc_q) && $stable(status_q));

  a_r11_prid_fixed: assert property (@(posedge clk) disable iff (rst)
    reg_num_i == REGNO_PRID |-> reg_rdata_o == PRID_VALUE);
endmodule

// File: tb/sysctl_cop_test.sv
module sysctl_cop_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_syscall_i = 1'b0;
  logic [31:0] cur_pc_i = '0;
  logic        in_dslot_i = 1'b0;
  logic [5:0]  irq_i = '0;
  logic        rfe_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [4:0]  reg_num_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        redirect_o;
  logic [31:0] redirect_pc_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  bit [31:0] m_status, m_cause, m_epc;

  sysctl_cop uut (.*);

  always #4 clk = ~clk;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] m_read(int n);
    if (n == 12) return m_status;
    if (n == 13) return m_cause;
    if (n == 14) return m_epc;
    if (n == 15) return 32'd2;
    return 32'd0;
  endfunction

  task automatic step(bit sys, bit ds, bit [31:0] pc, bit [5:0] irq, bit wr, int num,
                      bit [31:0] wd, bit rf, string tag);
    int masked;
    bit irq_go, sys_go, go;
    bit [31:0] ns, nc, ne;
    @(negedge clk);
    exc_syscall_i = sys; in_dslot_i = ds; cur_pc_i = pc; irq_i = irq;
    reg_wr_i = wr; reg_num_i = 5'(num); reg_wdata_i = wd; rfe_i = rf;
    #1;
    masked = int'(irq) & int'((m_status >> 8) & 32'h3F);
    irq_go = (m_status[0] == 1'b1) && (masked != 0);
    sys_go = sys && !ds;
    go = irq_go || sys_go;
    chk(redirect_o == go, tag, {31'b0, redirect_o}, {31'b0, go});
    if (go) chk(redirect_pc_o == 32'h8000_0080, tag, redirect_pc_o, 32'h8000_0080);
    chk(reg_rdata_o == m_read(num), tag, reg_rdata_o, m_read(num));
    ns = m_status; nc = m_cause; ne = m_epc;
    if (go) begin
      ns = (m_status & 32'hFFFF_FFC0) | ((m_status * 4) & 32'h3C);
      nc = irq_go ? 32'(masked) * 1024 : 32'd8 * 4;
      ne = ds ? pc - 4 : pc;
    end else begin
      if (rf) ns = (m_status & 32'hFFFF_FFF0) | ((m_status / 4) & 32'hF);
      else if (wr && num == 12) ns = wd;
      if (wr && num == 13) nc = wd;
      if (wr && num == 14) ne = wd;
    end
    @(posedge clk);
    m_status = ns; m_cause = nc; m_epc = ne;
  endtask

  task automatic rd(int num, string tag);
    step(0, 0, 0, 0, 0, num, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset redirect
    repeat (2) @(negedge clk);
    chk(redirect_o == 1'b1, "R1", {31'b0, redirect_o}, 32'd1);
    chk(redirect_pc_o == 32'hBFC0_0000, "R1", redirect_pc_o, 32'hBFC0_0000);
    @(negedge clk);
    rst = 1'b0;
    m_status = 0; m_cause = 0; m_epc = 0;
    rd(12, "R1"); rd(13, "R1"); rd(14, "R1"); rd(15, "R1");
    rd(7, "R10"); rd(31, "R10");
    // R11 / R10: ignored writes
    step(0, 0, 0, 0, 1, 15, 32'hFFFF_FFFF, 0, "R11");
    rd(15, "R11");
    step(0, 0, 0, 0, 1, 3, 32'h1234_5678, 0, "R10");
    rd(3, "R10"); rd(12, "R10");
    // R7: global enable off, mask on
    step(0, 0, 0, 0, 1, 12, 32'h0000_3F00, 0, "R10");
    step(0, 0, 32'h40, 6'h3F, 0, 12, 0, 0, "R7");
    // enable line 0 only, request another line
    step(0, 0, 0, 0, 1, 12, 32'h0000_0105, 0, "R10");
    step(0, 0, 32'h40, 6'h02, 0, 12, 0, 0, "R7");
    // interrupt in a delay slot
    step(0, 1, 32'h100, 6'h03, 0, 13, 0, 0, "R7");
    rd(12, "R2"); rd(13, "R4"); rd(14, "R5");
    // return
    step(0, 0, 0, 0, 0, 12, 0, 1, "R3");
    rd(12, "R3");
    // system call outside a slot
    step(1, 0, 32'h200, 0, 0, 14, 0, 0, "R6");
    rd(13, "R4"); rd(14, "R5"); rd(12, "R2");
    // system call in a slot: ignored
    step(1, 1, 32'h300, 0, 0, 13, 0, 0, "R8");
    rd(13, "R8"); rd(14, "R8"); rd(12, "R8");
    // call and interrupt together
    step(0, 0, 0, 0, 1, 12, 32'h0000_2001, 0, "R10");
    step(1, 0, 32'h400, 6'h20, 0, 13, 0, 0, "R9");
    rd(13, "R9");
    // exception with same-cycle write / return
    step(0, 0, 0, 0, 1, 12, 32'h0000_0401, 0, "R10");
    step(0, 0, 32'h500, 6'h04, 1, 14, 32'hDEAD_BEEF, 1, "R12");
    rd(14, "R12"); rd(12, "R12");
    // return with same-cycle status write
    step(0, 0, 0, 0, 1, 12, 32'hFFFF_FFFF, 1, "R12");
    rd(12, "R12");
    // mixed stimulus against the model
    for (int i = 0; i < 800; i++) begin
      bit sys, ds, wr, rf;
      bit [5:0] irq;
      int num;
      string tag;
      sys = ($urandom % 6) == 0;
      ds  = ($urandom % 2) == 0;
      irq = (($urandom % 3) == 0) ? 6'($urandom) : 6'd0;
      wr  = ($urandom % 5) == 0;
      rf  = ($urandom % 9) == 0;
      num = (($urandom % 4) == 0) ? int'($urandom % 32) : 12 + int'($urandom % 4);
      if (sys || irq != 0) tag = "R7";
      else if (rf) tag = "R3";
      else tag = "R10";
      step(sys, ds, $urandom & 32'hFFFF_FFFC, irq, wr, num, $urandom, rf, tag);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule